// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block sits between one core and a shared broadcast bus. It owns a small direct-mapped, write-back private cache of one data word per line, and it keeps that cache coherent with its peers by invalidation. Loads and stores from the core hit locally where the line state allows. Otherwise the controller requests the bus, waits for the grant from an external arbiter, and issues a read-miss, write-miss or invalidate transaction. A dirty victim is first written back, inside the same bus tenure.

Every controller watches every transaction that another master puts on the bus. Matching lines are dropped on invalidates and write-misses. A controller that holds the addressed line dirty answers a miss by driving the line data and raising an intervene flag. Memory then takes that data in place of its own copy and forwards it as the fill. This refreshes memory at the moment a dirty line becomes shared.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_ready`, `bus_req`, `mst_valid`, `snp_int` and `snp_shared` are low, so the first load of any address goes to the bus.
- R2: A load that hits a Shared or Modified line raises `cpu_ready` for exactly one cycle, in the cycle after acceptance, with the line data on `cpu_rdata` and no bus request.
- R3: A store that hits a Modified line completes in one cycle with no bus request, and later loads return the stored value.
- R4: A load miss raises `bus_req`, issues command code 0 (read-miss) once granted, installs the fill as Shared and returns the fill data.
- R5: A store that hits a Shared line stalls until the grant, broadcasts command code 2 (invalidate) with the line address, and then holds the line Modified.
- R6: A store miss issues command code 1 (write-miss), waits for the fill and holds the line Modified with the store data.
- R7: A foreign read-miss that hits a Modified line drives `snp_int` high and the line data on `snp_data` in the following cycle, and moves the line to Shared. Memory takes that data at the same time as the fill.
- R8: A foreign write-miss or invalidate that hits a valid line makes it Invalid. On a write-miss the line data is supplied through `snp_int` and `snp_data` when the line was Modified.
- R9: A foreign read-miss that hits a Shared line drives `snp_shared` in the following cycle, and never together with `snp_int`.
- R10: A miss whose victim line is Modified issues command code 3 (write-back) with the victim address and data, and issues the miss command in the very next cycle of the same grant.
- R11: The action is chosen when the grant arrives. A store whose Shared line was invalidated while it waited issues a write-miss rather than an invalidate, so simultaneous writers are serialized.
- R12: `mst_valid` is only high while both `bus_req` and `bus_gnt` are high.
- R13: At most one controller intervenes in any cycle, and every load returns the most recently completed store to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Core request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mst_valid | output | 1 | This controller drives a command this cycle |
| mst_cmd | output | 2 | 0 read-miss, 1 write-miss, 2 invalidate, 3 write-back |
| mst_addr | output | ADDR_W | Command address |
| mst_data | output | DATA_W | Write-back data |
| bus_valid | input | 1 | A command is on the shared bus |
| bus_cmd | input | 2 | Command on the shared bus |
| bus_addr | input | ADDR_W | Address on the shared bus |
| snp_shared | output | 1 | Snooped read-miss found a Shared copy here |
| snp_int | output | 1 | Intervention: this cache supplies the data |
| snp_data | output | DATA_W | Data supplied by intervention |
| fill_valid | input | 1 | Fill data for the pending miss |
| fill_data | input | DATA_W | Fill data |

## Verification
Local hits and stores to Modified lines are due one cycle after acceptance, so the bench measures the latency in cycles at the falling edge and expects exactly one. Snoop responses are registered and appear one cycle after the foreign command. The bench memory model samples them there and either forwards the intervened data one cycle later or supplies its own after a fixed latency. A write-back must be followed by its miss in the next cycle, and the bench compares the cycle stamps of the two commands. Bus-side results are checked only after `cpu_ready`, when every command of the transaction has been counted. Loads are checked against a shadow memory that is updated in store completion order.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    CMD_RDMISS = 2'd0,
    CMD_WRMISS = 2'd1,
    CMD_INV    = 2'd2,
    CMD_WB     = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } lst_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_REQ,
    FS_WB,
    FS_CMD,
    FS_WAIT,
    FS_DONE
  } fsm_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_st,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [1:0]        a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [1:0]        b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data
);
  localparam int LINES = 1 << IDX_W;

  logic [1:0]        st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // state bits need a reset; tag and data arrays are plain RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_full) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_gnt,
  input  logic [1:0]        bus_cmd,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [1:0]        ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              upd_en,
  output logic [1:0]        upd_st,
  output logic              snp_shared,
  output logic              snp_int,
  output logic [DATA_W-1:0] snp_data
);
  logic hit, int_n, shr_n;

  // only commands driven by another master are snooped
  assign hit = bus_valid && !bus_gnt && (ln_st != LN_INV) && (ln_tag == bus_tag);

  always_comb begin
    upd_en = 1'b0;
    upd_st = LN_INV;
    int_n  = 1'b0;
    shr_n  = 1'b0;
    if (hit) begin
      case (cmd_e'(bus_cmd))
        CMD_RDMISS: begin
          if (ln_st == LN_MOD) begin
            upd_en = 1'b1;
            upd_st = LN_SHR;
            int_n  = 1'b1;
          end else begin
            shr_n  = 1'b1;
          end
        end
        CMD_WRMISS: begin
          upd_en = 1'b1;
          upd_st = LN_INV;
          int_n  = (ln_st == LN_MOD);
        end
        CMD_INV: begin
          upd_en = 1'b1;
          upd_st = LN_INV;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_int    <= 1'b0;
      snp_shared <= 1'b0;
      snp_data   <= '0;
    end else begin
      snp_int    <= int_n;
      snp_shared <= shr_n;
      if (int_n) snp_data <= ln_data;
    end
  end
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mst_valid,
  output logic [1:0]        mst_cmd,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_data,
  input  logic              bus_valid,
  input  logic [1:0]        bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              snp_shared,
  output logic              snp_int,
  output logic [DATA_W-1:0] snp_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              st_q, st_n;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;

  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [1:0]        a_st;
  logic [TAG_W-1:0]  a_tag;
  logic [DATA_W-1:0] a_data;
  logic [1:0]        b_st;
  logic [TAG_W-1:0]  b_tag;
  logic [DATA_W-1:0] b_data;
  logic              a_hit, foreign, accept;

  logic              loc_en, loc_full;
  logic [1:0]        loc_st;
  logic [DATA_W-1:0] loc_data;
  logic              snp_upd;
  logic [1:0]        snp_st;
  logic [1:0]        iss_cmd, miss_cmd;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_data;
  logic              rd_load;
  logic [DATA_W-1:0] rd_val;

  logic              wr_en, wr_full;
  logic [IDX_W-1:0]  wr_idx;
  logic [1:0]        wr_st;

  assign look_addr = (st_q == FS_IDLE) ? cpu_addr : req_addr_q;
  assign look_idx  = look_addr[IDX_W-1:0];
  assign look_tag  = look_addr[ADDR_W-1:IDX_W];
  assign a_hit     = (a_st != LN_INV) && (a_tag == look_tag);
  assign foreign   = bus_valid && !bus_gnt;
  assign accept    = (st_q == FS_IDLE) && cpu_valid && !foreign;
  assign miss_cmd  = req_we_q ? CMD_WRMISS : CMD_RDMISS;

  coh_line_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) i_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_full(wr_full),
    .wr_idx (wr_idx),
    .wr_st  (wr_st),
    .wr_tag (look_tag),
    .wr_data(loc_data),
    .a_idx  (look_idx),
    .a_st   (a_st),
    .a_tag  (a_tag),
    .a_data (a_data),
    .b_idx  (bus_addr[IDX_W-1:0]),
    .b_st   (b_st),
    .b_tag  (b_tag),
    .b_data (b_data)
  );

  coh_snoop_unit #(
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) i_snoop (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (bus_cmd),
    .bus_tag   (bus_addr[ADDR_W-1:IDX_W]),
    .ln_st     (b_st),
    .ln_tag    (b_tag),
    .ln_data   (b_data),
    .upd_en    (snp_upd),
    .upd_st    (snp_st),
    .snp_shared(snp_shared),
    .snp_int   (snp_int),
    .snp_data  (snp_data)
  );

  // snoop updates and local updates never coincide (local ones need
  // either an idle bus or ownership of it); snoop still wins the port
  assign wr_en   = snp_upd || loc_en;
  assign wr_full = !snp_upd && loc_full;
  assign wr_idx  = snp_upd ? bus_addr[IDX_W-1:0] : look_idx;
  assign wr_st   = snp_upd ? snp_st : loc_st;

  always_comb begin
    st_n     = st_q;
    loc_en   = 1'b0;
    loc_full = 1'b0;
    loc_st   = LN_INV;
    loc_data = req_wdata_q;
    iss_cmd  = mst_cmd;
    iss_addr = mst_addr;
    iss_data = mst_data;
    rd_load  = 1'b0;
    rd_val   = a_data;
    case (st_q)
      FS_IDLE: begin
        if (accept) begin
          if (a_hit && (!cpu_we || a_st == LN_MOD)) begin
            st_n    = FS_DONE;
            rd_load = !cpu_we;
            if (cpu_we) begin
              loc_en   = 1'b1;
              loc_full = 1'b1;
              loc_st   = LN_MOD;
              loc_data = cpu_wdata;
            end
          end else begin
            st_n = FS_REQ;
          end
        end
      end
      FS_REQ: begin
        // decide with the line state as it stands at grant time
        if (bus_gnt) begin
          if (a_hit) begin
            st_n     = FS_CMD;
            iss_cmd  = CMD_INV;
            iss_addr = req_addr_q;
          end else if (a_st == LN_MOD) begin
            st_n     = FS_WB;
            iss_cmd  = CMD_WB;
            iss_addr = {a_tag, look_idx};
            iss_data = a_data;
          end else begin
            st_n     = FS_CMD;
            iss_cmd  = miss_cmd;
            iss_addr = req_addr_q;
          end
        end
      end
      FS_WB: begin
        loc_en   = 1'b1;
        loc_st   = LN_INV;
        st_n     = FS_CMD;
        iss_cmd  = miss_cmd;
        iss_addr = req_addr_q;
      end
      FS_CMD: begin
        if (mst_cmd == CMD_INV) begin
          loc_en   = 1'b1;
          loc_full = 1'b1;
          loc_st   = LN_MOD;
          st_n     = FS_DONE;
        end else begin
          st_n = FS_WAIT;
        end
      end
      FS_WAIT: begin
        if (fill_valid) begin
          loc_en   = 1'b1;
          loc_full = 1'b1;
          loc_st   = req_we_q ? LN_MOD : LN_SHR;
          loc_data = req_we_q ? req_wdata_q : fill_data;
          rd_load  = !req_we_q;
          rd_val   = fill_data;
          st_n     = FS_DONE;
        end
      end
      default: st_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= FS_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      bus_req     <= 1'b0;
      mst_valid   <= 1'b0;
      mst_cmd     <= '0;
      mst_addr    <= '0;
      mst_data    <= '0;
    end else begin
      st_q <= st_n;
      if (accept) begin
        req_we_q    <= cpu_we;
        req_addr_q  <= cpu_addr;
        req_wdata_q <= cpu_wdata;
      end
      cpu_ready <= (st_n == FS_DONE);
      if (rd_load) cpu_rdata <= rd_val;
      bus_req   <= (st_n inside {FS_REQ, FS_WB, FS_CMD, FS_WAIT});
      mst_valid <= (st_n inside {FS_WB, FS_CMD}) && (st_q != FS_CMD);
      mst_cmd   <= iss_cmd;
      mst_addr  <= iss_addr;
      mst_data  <= iss_data;
    end
  end
endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       mst_valid,
  input logic [1:0] mst_cmd,
  input logic       bus_valid,
  input logic [1:0] bus_cmd,
  input logic       snp_int,
  input logic       snp_shared
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_ready && !bus_req && !mst_valid && !snp_int && !snp_shared));

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_issue_granted_R12: assert property (@(posedge clk) disable iff (rst)
    mst_valid |-> (bus_gnt && bus_req));

  assert_wb_pair_R10: assert property (@(posedge clk) disable iff (rst)
    (mst_valid && mst_cmd == 2'd3) |=> (mst_valid && !mst_cmd[1]));

  assert_int_cause_R7: assert property (@(posedge clk) disable iff (rst)
    snp_int |-> $past(bus_valid && !bus_gnt && !bus_cmd[1]));

  assert_excl_resp_R9: assert property (@(posedge clk) disable iff (rst)
    !(snp_int && snp_shared));
endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mst_valid (mst_valid),
  .mst_cmd   (mst_cmd),
  .bus_valid (bus_valid),
  .bus_cmd   (bus_cmd),
  .snp_int   (snp_int),
  .snp_shared(snp_shared)
);

// File: tb/test_coh_snoop_ctrl.sv
`timescale 1ns/1ps
module test_coh_snoop_ctrl;
  localparam int AW = 8, DW = 16, NC = 2, LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cv  [NC];
  logic          cwe [NC];
  logic [AW-1:0] ca  [NC];
  logic [DW-1:0] cwd [NC];
  logic [DW-1:0] crd [NC];
  logic [NC-1:0] crdy, breq, bgnt, mv, sint, ssh;
  logic [1:0]    mcmd [NC];
  logic [AW-1:0] madr [NC];
  logic [DW-1:0] mdat [NC];
  logic [DW-1:0] sdat [NC];
  logic          bus_valid;
  logic [1:0]    bcmd;
  logic [AW-1:0] badr;
  logic [DW-1:0] bdat;
  logic          fvld;
  logic [DW-1:0] fdat;

  for (genvar k = 0; k < NC; k++) begin : g_core
    coh_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2)) i_coh_snoop_ctrl (
      .clk(clk), .rst(rst),
      .cpu_valid(cv[k]), .cpu_we(cwe[k]), .cpu_addr(ca[k]), .cpu_wdata(cwd[k]),
      .cpu_ready(crdy[k]), .cpu_rdata(crd[k]),
      .bus_req(breq[k]), .bus_gnt(bgnt[k]),
      .mst_valid(mv[k]), .mst_cmd(mcmd[k]), .mst_addr(madr[k]), .mst_data(mdat[k]),
      .bus_valid(bus_valid), .bus_cmd(bcmd), .bus_addr(badr),
      .snp_shared(ssh[k]), .snp_int(sint[k]), .snp_data(sdat[k]),
      .fill_valid(fvld), .fill_data(fdat)
    );
  end

  // bus multiplexer
  always_comb begin
    bus_valid = 1'b0; bcmd = '0; badr = '0; bdat = '0;
    for (int k = 0; k < NC; k++)
      if (bgnt[k]) begin
        bus_valid = mv[k]; bcmd = mcmd[k]; badr = madr[k]; bdat = mdat[k];
      end
  end

  // arbiter: grant held while requested, alternating preference
  int last_win;
  always @(posedge clk) begin
    if (rst) begin
      bgnt <= '0; last_win <= 1;
    end else if (bgnt != '0) begin
      if ((bgnt & breq) == '0) bgnt <= '0;
    end else if (breq != '0) begin
      if (breq[0] && (last_win == 1 || !breq[1])) begin
        bgnt <= 2'b01; last_win <= 0;
      end else begin
        bgnt <= 2'b10; last_win <= 1;
      end
    end
  end

  function automatic logic [DW-1:0] init_val(int a);
    return {a[7:0], ~a[7:0] ^ 8'h3C};
  endfunction

  // memory model
  logic [DW-1:0] mem [256];
  int            phase, cnt;
  logic [AW-1:0] padr;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      phase <= 0; cnt <= 0; fvld <= 1'b0; fdat <= '0; padr <= '0;
    end else begin
      fvld <= 1'b0;
      if (bus_valid && bcmd == 2'd3) mem[badr] <= bdat;
      if (bus_valid && !bcmd[1]) begin
        padr <= badr; phase <= 1;
      end else if (phase == 1) begin
        if (sint != '0) begin
          mem[padr] <= sint[0] ? sdat[0] : sdat[1];
          fdat <= sint[0] ? sdat[0] : sdat[1];
          fvld <= 1'b1; phase <= 0;
        end else begin
          cnt <= LAT; phase <= 2;
        end
      end else if (phase == 2) begin
        if (cnt == 0) begin
          fdat <= mem[padr]; fvld <= 1'b1; phase <= 0;
        end else cnt <= cnt - 1;
      end
    end
  end

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor
  int ncmd [4];
  int cyc = 0;
  logic [NC-1:0] seen_int, seen_sh;
  int h_cmd [2], h_adr [2], h_dat [2], h_cyc [2];
  initial begin
    for (int i = 0; i < 4; i++) ncmd[i] = 0;
    seen_int = '0; seen_sh = '0;
    for (int i = 0; i < 2; i++) begin h_cmd[i] = 0; h_adr[i] = 0; h_dat[i] = 0; h_cyc[i] = 0; end
  end
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (bus_valid) begin
        ncmd[bcmd]++;
        h_cmd[0] = h_cmd[1]; h_adr[0] = h_adr[1]; h_dat[0] = h_dat[1]; h_cyc[0] = h_cyc[1];
        h_cmd[1] = int'(bcmd); h_adr[1] = int'(badr); h_dat[1] = int'(bdat); h_cyc[1] = cyc;
      end
      seen_int = seen_int | sint;
      seen_sh  = seen_sh | ssh;
      if (sint == 2'b11) check(1'b0, "R13 two interveners", int'(sint), 1);
    end
  end

  logic [DW-1:0] shadow [256];

  task automatic op(input int c, input bit we, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string tag, output int lat);
    logic [DW-1:0] r;
    @(negedge clk);
    cv[c] = 1'b1; cwe[c] = we; ca[c] = a; cwd[c] = d; lat = 0;
    do begin @(negedge clk); lat++; end while (!crdy[c] && lat < 3000);
    cv[c] = 1'b0; r = crd[c];
    if (lat >= 3000) check(1'b0, {tag, " timeout"}, lat, 0);
    else if (we) shadow[a] = d;
    else check(r == shadow[a], tag, int'(r), int'(shadow[a]));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  int lat, l0, l1, b_rd, b_wr, b_inv;
  time t0, t1;
  localparam logic [AW-1:0] A = 8'h05, B = 8'h09, C = 8'h0A;

  initial begin
    void'($urandom(32'd7331));
    for (int k = 0; k < NC; k++) begin cv[k] = 0; cwe[k] = 0; ca[k] = '0; cwd[k] = '0; end
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(crdy == '0 && breq == '0 && mv == '0, "R1 outputs after reset", int'({crdy, breq, mv}), 0);
    check(sint == '0 && ssh == '0, "R1 snoop flags after reset", int'({sint, ssh}), 0);

    // R4 load miss, lines start invalid (R1)
    b_rd = ncmd[0];
    op(0, 0, A, '0, "R4 load miss data", lat);
    check(ncmd[0] == b_rd + 1, "R1 R4 read-miss issued", ncmd[0] - b_rd, 1);

    // R2 load hit
    b_rd = ncmd[0];
    op(0, 0, A, '0, "R2 load hit data", lat);
    check(lat == 1, "R2 hit latency", lat, 1);
    check(ncmd[0] == b_rd, "R2 no bus traffic", ncmd[0] - b_rd, 0);

    // R9 second reader sees shared copy
    seen_sh = '0;
    op(1, 0, A, '0, "R9 load by peer", lat);
    check(seen_sh[0], "R9 shared response", int'(seen_sh), 1);

    // R5 store to shared line broadcasts invalidate
    b_inv = ncmd[2];
    op(0, 1, A, 16'h1111, "R5 store", lat);
    check(ncmd[2] == b_inv + 1, "R5 invalidate issued", ncmd[2] - b_inv, 1);
    check(h_adr[1] == int'(A), "R5 invalidate address", h_adr[1], int'(A));

    // R8 peer copy invalidated, R7 intervention with memory update
    b_rd = ncmd[0]; seen_int = '0;
    op(1, 0, A, '0, "R7 load via intervention", lat);
    check(ncmd[0] == b_rd + 1, "R8 peer missed after invalidate", ncmd[0] - b_rd, 1);
    check(seen_int == 2'b01, "R7 intervention by owner", int'(seen_int), 1);
    check(mem[A] == 16'h1111, "R7 memory updated on sharing", int'(mem[A]), 16'h1111);

    // owner is Shared again: upgrade, then R3 store to Modified
    b_inv = ncmd[2];
    op(0, 1, A, 16'h2222, "R5 second upgrade", lat);
    check(ncmd[2] == b_inv + 1, "R5 second invalidate", ncmd[2] - b_inv, 1);
    b_inv = ncmd[0] + ncmd[1] + ncmd[2] + ncmd[3];
    op(0, 1, A, 16'h3333, "R3 store hit", lat);
    check(lat == 1, "R3 store latency", lat, 1);
    check(ncmd[0] + ncmd[1] + ncmd[2] + ncmd[3] == b_inv, "R3 no bus traffic", 0, 0);
    op(0, 0, A, '0, "R3 load after store", lat);

    // R10 dirty victim: write-back then write-miss (R6)
    b_wr = ncmd[1];
    op(0, 1, B, 16'h4444, "R6 store miss", lat);
    check(ncmd[1] == b_wr + 1, "R6 write-miss issued", ncmd[1] - b_wr, 1);
    check(h_cmd[0] == 3 && h_adr[0] == int'(A) && h_dat[0] == 16'h3333, "R10 write-back fields",
          h_dat[0], 16'h3333);
    check(h_cmd[1] == 1 && h_adr[1] == int'(B) && h_cyc[1] == h_cyc[0] + 1, "R10 miss follows at once",
          h_cyc[1] - h_cyc[0], 1);
    check(mem[A] == 16'h3333, "R10 memory holds victim", int'(mem[A]), 16'h3333);
    op(0, 0, B, '0, "R6 load after store miss", lat);
    check(lat == 1, "R6 line held after fill", lat, 1);

    // R8 write-miss against a Modified copy
    seen_int = '0;
    op(1, 1, B, 16'h5555, "R8 peer store", lat);
    check(seen_int == 2'b01, "R8 owner supplied data", int'(seen_int), 1);
    b_rd = ncmd[0];
    op(0, 0, B, '0, "R8 old owner reads new value", lat);
    check(ncmd[0] == b_rd + 1, "R8 old owner invalidated", ncmd[0] - b_rd, 1);

    // R11 simultaneous stores to a shared line
    op(0, 0, C, '0, "R11 prime 0", lat);
    op(1, 0, C, '0, "R11 prime 1", lat);
    b_inv = ncmd[2]; b_wr = ncmd[1];
    fork
      begin op(0, 1, C, 16'h6666, "R11 store 0", l0); t0 = $time; end
      begin op(1, 1, C, 16'h7777, "R11 store 1", l1); t1 = $time; end
    join
    check(t0 != t1, "R11 stores serialized", int'(t0 == t1), 0);
    check(ncmd[2] == b_inv + 1, "R11 one invalidate", ncmd[2] - b_inv, 1);
    check(ncmd[1] == b_wr + 1, "R11 loser write-miss", ncmd[1] - b_wr, 1);
    op(0, 0, C, '0, "R11 load 0 sees last store", lat);
    op(1, 0, C, '0, "R11 load 1 sees last store", lat);

    // R13 random traffic against the shadow memory
    for (int n = 0; n < 400; n++) begin
      int c;
      bit we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      c  = int'($urandom % NC);
      we = 1'($urandom % 2);
      a  = AW'($urandom % 16);
      d  = DW'($urandom);
      op(c, we, a, d, "R13 random load", lat);
    end

    finish_run();
  end
endmodule